// File: doc/BRIEF.md
# BCD calendar time counter

This block keeps the time of day and the calendar date in seven byte-wide registers, every field held as packed BCD. A pulse on `sub_tick` moves a sub-second phase counter on. Once `TICKS_PER_SEC` pulses have arrived, the seconds advance. A carry then ripples in the same cycle through minutes, hours, the day of the week, the date, the month and a two-digit year. A halt flag shares the seconds register and stops all counting. A mode flag in the hours register switches the hour field between a 24-hour layout and a 12-hour layout with a PM flag.

A bus front end loads a field by placing an address and a byte on the write port for one cycle with `wr_en` high. It reads a register through a combinational read port. Bits of a register that hold no field are dropped on write and read back as zero. If a write and an advance land on the same register in the same cycle, the write wins.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the registers read 00 s, 00 min, 00 h in 24-hour mode, weekday 1, date 01, month 01, year 00, and the halt flag is clear.
- R2: Register 0 holds seconds 00–59 (BCD, bits 6:0). Seconds advance by one on every `TICKS_PER_SEC`-th `sub_tick` pulse, wrap from 59 to 00 and carry into the minutes.
- R3: Register 1 holds minutes 00–59 (BCD, bits 6:0). Minutes wrap from 59 to 00 and carry into the hours.
- R4: When bit 6 of register 2 is clear (24-hour mode), bits 5:0 hold the hour 00–23 in BCD. The hour wraps from 23 to 00 and advances the weekday and the date.
- R5: When bit 6 of register 2 is set (12-hour mode), bit 5 is PM and bits 4:0 hold the hour 01–12 in BCD. Hour 11 goes to 12 and toggles PM. Hour 12 goes to 01 with PM unchanged. Weekday and date advance only on 11 PM to 12 AM.
- R6: Register 3 holds the weekday 1–7 in bits 2:0 and wraps from 7 to 1. Bits 7:3 always read zero.
- R7: Register 4 holds the date (BCD, bits 5:0). Once the date is at or past the last day of the month, it wraps to 01 and carries into the month. The last day is 30 for months 04, 06, 09 and 11. For month 02 it is 29 when the year is a multiple of four and 28 otherwise. Every other month ends on 31.
- R8: Register 5 holds the month 01–12 (BCD, bits 4:0) and wraps from 12 to 01, carrying into register 6. Register 6 holds the year 00–99 (BCD, all 8 bits) and wraps from 99 to 00.
- R9: While bit 7 of register 0 (halt) is set, no register and no sub-second phase changes except by a write.
- R10: A write with `wr_en` high loads register `wr_addr` (0–6), masked to its fields: masks FF, 7F, 7F, 07, 3F, 1F, FF. Address 7 is ignored and reads as 00.
- R11: A write to a register takes priority over that register's advance in the same cycle. A write to register 0 also clears the sub-second phase and cancels that cycle's second step together with its carries.
- R12: `rd_data` shows the register chosen by `rd_addr` in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sub_tick | input | 1 | Sub-second pulse, one cycle wide |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register written |
| wr_data | input | 8 | Byte written |
| rd_addr | input | 3 | Register read |
| rd_data | output | 8 | Selected register contents |

## Verification
The bench drives the design into each rollover: the end of February in leap and common years, a 30-day month, and the last second of a century. A design with a wrong month-length table would count the date to 29, 30 or 31 where it should wrap. The 12-hour cases at 11 AM, 11 PM and 12 check the PM toggle and the day carry. A design that toggles on 12 to 1, or carries on 11 AM, shows a wrong hour byte or a weekday one ahead. Halt, write-versus-advance collisions and phase restart on a seconds write are driven at cycle-exact points. A design that lets a carry escape under halt, or keeps the old sub-second phase, moves a second early or late against the reference model.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NUM_REGS = 7;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RG_SEC  = 3'd0,
    RG_MIN  = 3'd1,
    RG_HOUR = 3'd2,
    RG_WDAY = 3'd3,
    RG_DATE = 3'd4,
    RG_MON  = 3'd5,
    RG_YEAR = 3'd6
  } reg_idx_e;

  // Field masks applied on write
  localparam logic [BYTE_W-1:0] MASK_SEC  = 8'hFF;
  localparam logic [BYTE_W-1:0] MASK_MIN  = 8'h7F;
  localparam logic [BYTE_W-1:0] MASK_HOUR = 8'h7F;
  localparam logic [BYTE_W-1:0] MASK_WDAY = 8'h07;
  localparam logic [BYTE_W-1:0] MASK_DATE = 8'h3F;
  localparam logic [BYTE_W-1:0] MASK_MON  = 8'h1F;
  localparam logic [BYTE_W-1:0] MASK_YEAR = 8'hFF;

  // Two-digit BCD increment, no wrap handling
  function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
    if (v[3:0] >= 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return {v[7:4], v[3:0] + 4'h1};
  endfunction

  // Year multiple of four, tested digit-wise
  function automatic logic bcd_leap(input logic [BYTE_W-1:0] y);
    if (!y[4]) return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
    return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
  endfunction

  // Last date of a month as BCD
  function automatic logic [BYTE_W-1:0] month_last(input logic [BYTE_W-1:0] m,
                                                   input logic [BYTE_W-1:0] y);
    case (m)
      8'h02: return bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  // Next hour byte for either layout
  function automatic logic [BYTE_W-1:0] hour_advance(input logic [BYTE_W-1:0] h);
    logic [BYTE_W-1:0] t;
    if (h[6]) begin
      if (h[4:0] == 5'h12) return {2'b01, h[5], 5'h01};
      if (h[4:0] == 5'h11) return {2'b01, ~h[5], 5'h12};
      t = bcd_inc({3'b000, h[4:0]});
      return {2'b01, h[5], t[4:0]};
    end
    if (h[5:0] >= 6'h23) return 8'h00;
    t = bcd_inc({2'b00, h[5:0]});
    return {2'b00, t[5:0]};
  endfunction

  // Hour byte at which the next advance rolls into a new day
  function automatic logic is_day_end(input logic [BYTE_W-1:0] h);
    if (h[6]) return h[5] && (h[4:0] == 5'h11);
    return h[5:0] >= 6'h23;
  endfunction

endpackage

// File: rtl/bcc_second_phase.sv
module bcc_second_phase #(
  parameter int unsigned TICKS_PER_SEC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic restart,
  output logic sec_step
);

  generate
    if (TICKS_PER_SEC <= 1) begin : g_direct
      assign sec_step = tick && run && !restart;

      a_r11_restart_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> !sec_step);
    end else begin : g_count
      localparam int unsigned PW = $clog2(TICKS_PER_SEC);
      localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

      logic [PW-1:0] phase_q;
      logic          at_last;

      assign at_last  = (phase_q == LAST);
      assign sec_step = tick && run && !restart && at_last;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            phase_q <= '0;
        else if (restart)      phase_q <= '0;
        else if (tick && run)  phase_q <= at_last ? '0 : phase_q + PW'(1);
      end

      // R11: a fresh phase needs more than one tick before the next step
      a_r11_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !sec_step);
      // R9: halted phase does not move
      a_r9_phase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(phase_q));
    end
  endgenerate

endmodule

// File: rtl/bcc_clock_chain.sv
module bcc_clock_chain
  import bcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_step,
  input  logic              wr_sec,
  input  logic              wr_min,
  input  logic              wr_hour,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] sec_q,
  output logic [BYTE_W-1:0] min_q,
  output logic [BYTE_W-1:0] hour_q,
  output logic              halted,
  output logic              day_step
);

  logic sec_wrap, min_wrap;
  logic [BYTE_W-1:0] sec_inc, min_inc;

  assign halted   = sec_q[7];
  assign sec_wrap = sec_step && (sec_q[6:0] >= 7'h59);
  assign min_wrap = sec_wrap && (min_q[6:0] >= 7'h59);
  assign day_step = min_wrap && is_day_end(hour_q);
  assign sec_inc  = bcd_inc({1'b0, sec_q[6:0]});
  assign min_inc  = bcd_inc({1'b0, min_q[6:0]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
    end else begin
      if (wr_sec)        sec_q <= wr_data & MASK_SEC;
      else if (sec_step) sec_q <= {sec_q[7], sec_wrap ? 7'h00 : sec_inc[6:0]};

      if (wr_min)        min_q <= wr_data & MASK_MIN;
      else if (sec_wrap) min_q <= min_wrap ? 8'h00 : {1'b0, min_inc[6:0]};

      if (wr_hour)       hour_q <= wr_data & MASK_HOUR;
      else if (min_wrap) hour_q <= hour_advance(hour_q);
    end
  end

  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wrap |=> (sec_q[6:0] == 7'h00));
  a_r3_min_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_wrap && !wr_min) |=> (min_q != $past(min_q)));
  a_r5_noon_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (min_wrap && !wr_hour && hour_q[6] && hour_q[4:0] == 5'h11)
      |=> (hour_q[5] != $past(hour_q[5])));
  a_r5_one_keeps_pm: assert property (@(posedge clk) disable iff (!rst_n)
    (min_wrap && !wr_hour && hour_q[6] && hour_q[4:0] == 5'h12)
      |=> (hour_q[5] == $past(hour_q[5]) && hour_q[4:0] == 5'h01));
  a_r4_midnight: assert property (@(posedge clk) disable iff (!rst_n)
    (min_wrap && !wr_hour && !hour_q[6] && hour_q[5:0] == 6'h23)
      |=> (hour_q == 8'h00));

endmodule

// File: rtl/bcc_date_chain.sv
module bcc_date_chain
  import bcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              day_step,
  input  logic              wr_wday,
  input  logic              wr_date,
  input  logic              wr_mon,
  input  logic              wr_year,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] wday_q,
  output logic [BYTE_W-1:0] date_q,
  output logic [BYTE_W-1:0] mon_q,
  output logic [BYTE_W-1:0] year_q
);

  logic date_wrap, mon_wrap;
  logic [BYTE_W-1:0] last_date;

  assign last_date = month_last(mon_q, year_q);
  assign date_wrap = day_step && (date_q >= last_date);
  assign mon_wrap  = date_wrap && (mon_q >= 8'h12);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wday_q <= 8'h01;
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      year_q <= 8'h00;
    end else begin
      if (wr_wday)       wday_q <= wr_data & MASK_WDAY;
      else if (day_step) wday_q <= (wday_q >= 8'h07) ? 8'h01 : wday_q + 8'h01;

      if (wr_date)       date_q <= wr_data & MASK_DATE;
      else if (day_step) date_q <= date_wrap ? 8'h01 : bcd_inc(date_q);

      if (wr_mon)         mon_q <= wr_data & MASK_MON;
      else if (date_wrap) mon_q <= mon_wrap ? 8'h01 : bcd_inc(mon_q);

      if (wr_year)       year_q <= wr_data & MASK_YEAR;
      else if (mon_wrap) year_q <= (year_q >= 8'h99) ? 8'h00 : bcd_inc(year_q);
    end
  end

  a_r6_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && !wr_wday && wday_q == 8'h07) |=> (wday_q == 8'h01));
  a_r7_date_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (date_wrap && !wr_date) |=> (date_q == 8'h01));
  a_r8_year_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_wrap && !wr_year && year_q == 8'h99) |=> (year_q == 8'h00));
  a_r8_month_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_wrap && !wr_mon) |=> (mon_q == 8'h01));

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import bcc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sub_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);

  logic [NUM_REGS-1:0] wr_sel;
  logic                sec_step, day_step, halted;
  logic [BYTE_W-1:0]   sec_q, min_q, hour_q, wday_q, date_q, mon_q, year_q;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_wsel
      assign wr_sel[gi] = wr_en && (wr_addr == ADDR_W'(gi));
    end
  endgenerate

  bcc_second_phase #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sub_tick),
    .run      (!halted),
    .restart  (wr_sel[RG_SEC]),
    .sec_step (sec_step)
  );

  bcc_clock_chain u_clock (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_step (sec_step),
    .wr_sec   (wr_sel[RG_SEC]),
    .wr_min   (wr_sel[RG_MIN]),
    .wr_hour  (wr_sel[RG_HOUR]),
    .wr_data  (wr_data),
    .sec_q    (sec_q),
    .min_q    (min_q),
    .hour_q   (hour_q),
    .halted   (halted),
    .day_step (day_step)
  );

  bcc_date_chain u_date (
    .clk      (clk),
    .rst_n    (rst_n),
    .day_step (day_step),
    .wr_wday  (wr_sel[RG_WDAY]),
    .wr_date  (wr_sel[RG_DATE]),
    .wr_mon   (wr_sel[RG_MON]),
    .wr_year  (wr_sel[RG_YEAR]),
    .wr_data  (wr_data),
    .wday_q   (wday_q),
    .date_q   (date_q),
    .mon_q    (mon_q),
    .year_q   (year_q)
  );

  always_comb begin
    case (rd_addr)
      RG_SEC:  rd_data = sec_q;
      RG_MIN:  rd_data = min_q;
      RG_HOUR: rd_data = hour_q;
      RG_WDAY: rd_data = wday_q;
      RG_DATE: rd_data = date_q;
      RG_MON:  rd_data = mon_q;
      RG_YEAR: rd_data = year_q;
      default: rd_data = '0;
    endcase
  end

  a_r9_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !wr_en) |=> $stable({sec_q, min_q, hour_q, wday_q, date_q, mon_q, year_q}));
  a_r9_halt_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !sec_step);
  a_r10_wr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));
  a_r6_wday_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == RG_WDAY) |-> (rd_data[7:3] == 5'b0));
  a_r10_unused_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 3'd7) |-> (rd_data == 8'h00));

endmodule

// File: tb/test_bcd_calendar_clock.sv
`timescale 1ns/10ps
module test_bcd_calendar_clock;

  localparam int TPS = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sub_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;

  int vectors = 0;
  int errors = 0;
  string cur_req = "R1";
  logic [7:0] m [0:6];
  int ph;

  always #2 clk = ~clk;

  bcd_calendar_clock #(.TICKS_PER_SEC(TPS)) i_bcd_calendar_clock (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic int b2i(input logic [7:0] x);
    return int'(x[7:4]) * 10 + int'(x[3:0]);
  endfunction
  function automatic logic [7:0] i2b(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction
  function automatic logic [7:0] fmask(input int a);
    case (a)
      1: return 8'h7F; 2: return 8'h7F; 3: return 8'h07;
      4: return 8'h3F; 5: return 8'h1F; default: return 8'hFF;
    endcase
  endfunction
  function automatic int days_in(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction
  function automatic string req_of(input int a);
    case (a)
      0: return "R2"; 1: return "R3"; 2: return "R4/R5"; 3: return "R6";
      4: return "R7"; 5: return "R8"; 6: return "R8"; default: return "R10";
    endcase
  endfunction

  task automatic model_advance();
    int s, mi, h, d, dt, mo, y;
    bit c, pm, nd;
    s = b2i({1'b0, m[0][6:0]}) + 1; c = 0;
    if (s >= 60) begin s = 0; c = 1; end
    m[0] = {m[0][7], i2b(s)[6:0]};
    if (!c) return;
    mi = b2i(m[1]) + 1; c = 0;
    if (mi >= 60) begin mi = 0; c = 1; end
    m[1] = i2b(mi);
    if (!c) return;
    nd = 0;
    if (m[2][6]) begin
      h = b2i({3'b000, m[2][4:0]}); pm = m[2][5];
      nd = (h == 11) && pm;
      if (h == 11) begin h = 12; pm = !pm; end
      else if (h == 12) h = 1;
      else h++;
      m[2] = {2'b01, pm, i2b(h)[4:0]};
    end else begin
      h = b2i(m[2]) + 1;
      if (h >= 24) begin h = 0; nd = 1; end
      m[2] = i2b(h);
    end
    if (!nd) return;
    d = int'(m[3]);
    m[3] = (d >= 7) ? 8'd1 : 8'(d + 1);
    dt = b2i(m[4]); mo = b2i(m[5]); y = b2i(m[6]);
    if (dt >= days_in(mo, y)) begin
      m[4] = 8'h01;
      if (mo >= 12) begin
        m[5] = 8'h01;
        m[6] = (y >= 99) ? 8'h00 : i2b(y + 1);
      end else m[5] = i2b(mo + 1);
    end else m[4] = i2b(dt + 1);
  endtask

  // Reference model, updated on the same edge as the design
  always @(posedge clk or negedge rst_n) begin
    bit adv;
    if (!rst_n) begin
      m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h00; m[3] = 8'h01;
      m[4] = 8'h01; m[5] = 8'h01; m[6] = 8'h00; ph = 0;
    end else begin
      adv = 0;
      if (wr_en && wr_addr == 3'd0) ph = 0;
      else if (sub_tick && !m[0][7]) begin
        if (ph == TPS - 1) begin ph = 0; adv = 1; end
        else ph++;
      end
      if (adv) model_advance();
      if (wr_en && wr_addr != 3'd7) m[wr_addr] = wr_data & fmask(int'(wr_addr));
    end
  end

  // R12: every register read back through the combinational port
  task automatic compare_all();
    logic [7:0] e;
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      #0.2;
      e = (a < 7) ? m[a] : 8'h00;
      vectors++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s [%s reg %0d] actual %h expected %h", req_of(a), cur_req, a, rd_data, e);
      end
    end
  endtask

  task automatic cycle(input bit t, input bit w, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    compare_all();
    sub_tick = t; wr_en = w; wr_addr = a; wr_data = d;
    @(posedge clk);
    #0.5;
    sub_tick = 1'b0; wr_en = 1'b0;
  endtask

  task automatic put(input logic [2:0] a, input logic [7:0] d);
    cycle(1'b0, 1'b1, a, d);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle(1'b1, 1'b0, 3'd0, 8'h00);
  endtask

  // Fixed expectation derived from the requirements, independent of the model
  task automatic expect_reg(input logic [2:0] a, input logic [7:0] v, input string req);
    @(negedge clk);
    compare_all();
    rd_addr = a;
    #0.2;
    vectors++;
    if (rd_data !== v) begin
      errors++;
      $display("FAIL %s [reg %0d] actual %h expected %h", req, a, rd_data, v);
    end
  endtask

  task automatic set_time(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt,
                          input logic [7:0] wd, input logic [7:0] hr, input logic [7:0] mi,
                          input logic [7:0] se);
    put(3'd6, yr); put(3'd5, mo); put(3'd4, dt); put(3'd3, wd);
    put(3'd2, hr); put(3'd1, mi); put(3'd0, se);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1 reset";
    expect_reg(3'd3, 8'h01, "R1");
    expect_reg(3'd0, 8'h00, "R1");

    cur_req = "R2 free run";
    run(3 * 70);

    cur_req = "R7 common February";
    set_time(8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
    run(3);
    expect_reg(3'd4, 8'h01, "R7");
    expect_reg(3'd5, 8'h03, "R7");
    expect_reg(3'd3, 8'h03, "R4");

    cur_req = "R7 leap February";
    set_time(8'h24, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h59);
    run(3);
    expect_reg(3'd4, 8'h29, "R7");
    expect_reg(3'd3, 8'h01, "R6");

    cur_req = "R7 thirty-day month";
    set_time(8'h24, 8'h04, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59);
    run(3);
    expect_reg(3'd5, 8'h05, "R7");

    cur_req = "R8 century wrap";
    set_time(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    run(3);
    expect_reg(3'd6, 8'h00, "R8");
    expect_reg(3'd5, 8'h01, "R8");
    expect_reg(3'd2, 8'h00, "R4");

    cur_req = "R5 11 PM to 12 AM";
    set_time(8'h10, 8'h06, 8'h15, 8'h04, 8'h71, 8'h59, 8'h59);
    run(3);
    expect_reg(3'd2, 8'h52, "R5");
    expect_reg(3'd4, 8'h16, "R5");

    cur_req = "R5 11 AM to 12 PM";
    set_time(8'h10, 8'h06, 8'h15, 8'h04, 8'h51, 8'h59, 8'h59);
    run(3);
    expect_reg(3'd2, 8'h72, "R5");
    expect_reg(3'd4, 8'h15, "R5");

    cur_req = "R5 12 to 1";
    put(3'd2, 8'h72); put(3'd1, 8'h59); put(3'd0, 8'h59);
    run(3);
    expect_reg(3'd2, 8'h61, "R5");

    cur_req = "R9 halt";
    put(3'd0, 8'h85);
    run(20);
    expect_reg(3'd0, 8'h85, "R9");
    put(3'd0, 8'h05);
    run(3);
    expect_reg(3'd0, 8'h06, "R9");

    cur_req = "R11 write beats carry";
    put(3'd1, 8'h20); put(3'd0, 8'h59);
    run(2);
    cycle(1'b1, 1'b1, 3'd1, 8'h10);
    expect_reg(3'd1, 8'h10, "R11");
    expect_reg(3'd0, 8'h00, "R11");

    cur_req = "R11 phase restart";
    put(3'd0, 8'h30);
    run(2);
    cycle(1'b1, 1'b1, 3'd0, 8'h20);
    run(2);
    expect_reg(3'd0, 8'h20, "R11");
    run(1);
    expect_reg(3'd0, 8'h21, "R11");

    cur_req = "R10 masks and hole";
    put(3'd3, 8'hFF);
    expect_reg(3'd3, 8'h07, "R10");
    put(3'd7, 8'hAA);
    expect_reg(3'd7, 8'h00, "R10");
    put(3'd4, 8'hD2);
    expect_reg(3'd4, 8'h12, "R10");

    cur_req = "R12 random traffic";
    put(3'd4, 8'h01);
    for (int i = 0; i < 6000; i++) begin
      int sel;
      logic [7:0] v;
      sel = int'($urandom_range(0, 99));
      if (sel < 6) begin
        int a;
        a = int'($urandom_range(0, 7));
        case (a)
          0: v = i2b(int'($urandom_range(50, 59))) | (($urandom_range(0, 9) == 0) ? 8'h80 : 8'h00);
          1: v = i2b(int'($urandom_range(55, 59)));
          2: v = ($urandom_range(0, 1) == 1)
                 ? {2'b01, 1'($urandom_range(0, 1)), i2b(int'($urandom_range(1, 12)))[4:0]}
                 : i2b(int'($urandom_range(20, 23)));
          3: v = 8'($urandom_range(1, 7));
          4: v = i2b(int'($urandom_range(1, 31)));
          5: v = i2b(int'($urandom_range(1, 12)));
          default: v = i2b(int'($urandom_range(0, 99)));
        endcase
        cycle(1'($urandom_range(0, 1)), 1'b1, 3'(a), v);
      end else begin
        cycle(1'b1, 1'b0, 3'd0, 8'h00);
      end
    end

    @(negedge clk);
    compare_all();
    finish_run();
  end

endmodule